// File: doc/BRIEF.md
# Instruction Step Timer for an Accumulator Machine

This block paces a single-bus accumulator processor through each instruction. A four-bit step counter starts at zero after reset and advances on every clock. It is decoded into sixteen one-hot time slots. The top four bits of the instruction register are sampled once per instruction. This gives a registered one-hot opcode decode and a mode flip-flop that marks indirect addressing. From the slot, the opcode and the mode, the block drives the bus source select and the load and increment strobes. These strobes fetch the instruction word, move its address field into the address register, and follow one level of indirection when one is requested.

The block sorts each instruction into three kinds. An instruction is memory-reference when its opcode is not all ones. It is register-reference when the opcode is all ones and the mode bit is clear. It is input-output when the opcode is all ones and the mode bit is set. The block emits a one-cycle execute strobe together with a two-bit kind code. The two non-memory kinds are handed off in the fourth slot, and the counter then returns to slot zero by itself. Memory-reference instructions are handed off in the fifth slot. The counter keeps running from there until the execution unit raises its finished input. The opcode datapath around the block carries out the instructions.

Top module: `instr_timing_seq`

## Requirements
- R1: After reset the step counter reads 0. It advances by one on every clock, and `t_slot` is always the one-hot decode of it (bit n high in slot n).
- R2: In slot 0 the block sets `bus_sel` = 2 (program counter) and raises `ar_ld`. No other strobe is active in that slot.
- R3: In slot 1 the block sets `bus_sel` = 7 (memory) and raises `mem_rd`, `ir_ld` and `pc_inr` together. `ar_ld` stays low.
- R4: In slot 2 the block sets `bus_sel` = 5 (instruction register) and raises `ar_ld`. On that edge it captures `ir_top[2:0]` (instruction bits 14..12), and from the next cycle `dec` is the one-hot decode of that value.
- R5: On the slot-2 edge, `mode_i` takes `ir_top[3]` (instruction bit 15) and holds it until the next slot-2 edge.
- R6: In slot 3, if the opcode is not 7 and `mode_i` = 1, the block sets `bus_sel` = 7 and raises `mem_rd` and `ar_ld`. If the opcode is not 7 and `mode_i` = 0, `bus_sel` = 0 and every strobe is low.
- R7: With opcode 7, slot 3 raises `exec_pulse` for one cycle. `exec_type` is then 1 when `mode_i` = 0 and 2 when `mode_i` = 1, and the next cycle is slot 0. With any other opcode, `exec_pulse` rises only in slot 4 and `exec_type` is 0. Outside a pulse, `exec_type` is 0.
- R8: For a memory-reference instruction, the counter keeps advancing from slot 4 and saturates at 15. When `done` is sampled high in slot 4 or later, the next cycle is slot 0.
- R9: `done` has no effect in slots 0 to 3, and it has no effect for an opcode-7 instruction.
- R10: A synchronous reset returns the counter to slot 0, clears `mode_i` and sets the captured opcode to 0, so `dec` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_top | input | 4 | Instruction register bits 15..12 (mode bit, opcode) |
| done | input | 1 | Memory-reference execution finished |
| t_slot | output | 16 | One-hot time slot |
| dec | output | 8 | One-hot captured opcode |
| mode_i | output | 1 | Indirect-mode flip-flop |
| bus_sel | output | 3 | Bus source select |
| ar_ld | output | 1 | Load address register from bus |
| pc_inr | output | 1 | Increment program counter |
| ir_ld | output | 1 | Load instruction register from bus |
| mem_rd | output | 1 | Memory read strobe |
| exec_pulse | output | 1 | One-cycle execute hand-off |
| exec_type | output | 2 | 0 memory-reference, 1 register-reference, 2 input-output |

## Verification
Two events can fall in one cycle. In slot 4, the execute hand-off of a memory-reference instruction can coincide with an immediate `done`. The sweep provokes this by raising `done` in the very slot where the strobe fires, and then expects both the pulse in that cycle and slot 0 in the next. The sweep also covers late finishes, a finish after the counter has saturated, and `done` raised in slots 2 and 3 where it must be ignored. Every cycle is compared with a per-slot table computed from the opcode and mode.

// File: rtl/instr_timing_seq.sv
module instr_timing_seq #(
  parameter int SC_W = 4,
  parameter int OP_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OP_W:0]          ir_top,
  input  logic                   done,
  output logic [(1<<SC_W)-1:0]   t_slot,
  output logic [(1<<OP_W)-1:0]   dec,
  output logic                   mode_i,
  output logic [2:0]             bus_sel,
  output logic                   ar_ld,
  output logic                   pc_inr,
  output logic                   ir_ld,
  output logic                   mem_rd,
  output logic                   exec_pulse,
  output logic [1:0]             exec_type
);
  localparam int NSLOT = 1 << SC_W;
  localparam int NOP   = 1 << OP_W;
  localparam logic [2:0] SEL_NONE = 3'd0;
  localparam logic [2:0] SEL_PC   = 3'd2;
  localparam logic [2:0] SEL_IR   = 3'd5;
  localparam logic [2:0] SEL_MEM  = 3'd7;

  logic [SC_W-1:0] sc;
  logic [OP_W-1:0] op_q;
  logic            mode_q;

  wire t0 = sc == SC_W'(0);
  wire t1 = sc == SC_W'(1);
  wire t2 = sc == SC_W'(2);
  wire t3 = sc == SC_W'(3);
  wire t4 = sc == SC_W'(4);
  wire d7 = &op_q;
  wire indir  = t3 && !d7 && mode_q;
  wire rr_end = t3 && d7;
  wire mr_end = !d7 && (sc >= SC_W'(4)) && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc     <= '0;
      op_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      if (rr_end || mr_end)
        sc <= '0;
      else if (sc != '1)
        sc <= sc + SC_W'(1);
      if (t2) begin
        op_q   <= ir_top[OP_W-1:0];
        mode_q <= ir_top[OP_W];
      end
    end
  end

  assign t_slot  = NSLOT'(1) << sc;
  assign dec     = NOP'(1) << op_q;
  assign mode_i  = mode_q;
  assign bus_sel = t0 ? SEL_PC : (t1 || indir) ? SEL_MEM : t2 ? SEL_IR : SEL_NONE;
  assign ar_ld   = t0 || t2 || indir;
  assign pc_inr  = t1;
  assign ir_ld   = t1;
  assign mem_rd  = t1 || indir;
  assign exec_pulse = rr_end || (t4 && !d7);
  assign exec_type  = rr_end ? (mode_q ? 2'd2 : 2'd1) : 2'd0;

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(t_slot) == 1); // R1
  AST_SLOT0_NEXT: assert property (@(posedge clk) disable iff (rst) t_slot[0] |=> t_slot[1]); // R1
  AST_FETCH_READ: assert property (@(posedge clk) disable iff (rst) t_slot[1] |-> (ir_ld && pc_inr && mem_rd && bus_sel == SEL_MEM && !ar_ld)); // R3
  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (rst) t_slot[2] |=> mode_i == $past(ir_top[OP_W])); // R5
  AST_RR_RESTART: assert property (@(posedge clk) disable iff (rst) (t_slot[3] && dec[NOP-1]) |=> t_slot[0]); // R7
  AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (rst) exec_pulse |=> !exec_pulse); // R7
  AST_DONE_RESTART: assert property (@(posedge clk) disable iff (rst) (done && !dec[NOP-1] && (t_slot[3:0] == 4'b0)) |=> t_slot[0]); // R8
  AST_EARLY_DONE: assert property (@(posedge clk) disable iff (rst) (t_slot[1] || t_slot[2]) |=> !t_slot[0]); // R9
endmodule

// File: tb/test_instr_timing_seq.sv
module test_instr_timing_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ir_top = 4'h0;
  logic done = 1'b0;
  logic [15:0] t_slot;
  logic [7:0] dec;
  logic mode_i, ar_ld, pc_inr, ir_ld, mem_rd, exec_pulse;
  logic [2:0] bus_sel;
  logic [1:0] exec_type;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  instr_timing_seq i_instr_timing_seq (
    .clk(clk), .rst(rst), .ir_top(ir_top), .done(done),
    .t_slot(t_slot), .dec(dec), .mode_i(mode_i), .bus_sel(bus_sel),
    .ar_ld(ar_ld), .pc_inr(pc_inr), .ir_ld(ir_ld), .mem_rd(mem_rd),
    .exec_pulse(exec_pulse), .exec_type(exec_type)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // packed strobes: {bus_sel, ar_ld, pc_inr, ir_ld, mem_rd, exec_pulse, exec_type}
  function automatic logic [9:0] pack(input logic [2:0] s, input logic a, input logic p,
                                      input logic i, input logic m, input logic e, input logic [1:0] t);
    return {s, a, p, i, m, e, t};
  endfunction

  task automatic run_instr(input logic [2:0] op, input logic md, input int done_at, input logic noise);
    logic d7 = (op == 3'd7);
    int last = d7 ? 3 : done_at;
    ir_top = {md, op};
    for (int k = 0; k <= last; k++) begin
      int es = (k > 15) ? 15 : k;
      logic [9:0] exp;
      string tag;
      done = (k == done_at) || (noise && (k == 2 || k == 3));
      #1;
      chk(k > 15 ? "R8 saturate" : "R1 slot", t_slot, 32'(16'(1) << es));
      case (es)
        0: begin exp = pack(3'd2, 1, 0, 0, 0, 0, 2'd0); tag = "R2"; end
        1: begin exp = pack(3'd7, 0, 1, 1, 1, 0, 2'd0); tag = "R3"; end
        2: begin exp = pack(3'd5, 1, 0, 0, 0, 0, 2'd0); tag = "R4"; end
        3: begin
          if (d7) begin exp = pack(3'd0, 0, 0, 0, 0, 1, md ? 2'd2 : 2'd1); tag = "R7 t3"; end
          else if (md) begin exp = pack(3'd7, 1, 0, 0, 1, 0, 2'd0); tag = "R6 indirect"; end
          else begin exp = pack(3'd0, 0, 0, 0, 0, 0, 2'd0); tag = "R6 direct"; end
        end
        4: begin exp = pack(3'd0, 0, 0, 0, 0, 1, 2'd0); tag = "R7 t4"; end
        default: begin exp = pack(3'd0, 0, 0, 0, 0, 0, 2'd0); tag = "R8 wait"; end
      endcase
      chk(tag, 32'(pack(bus_sel, ar_ld, pc_inr, ir_ld, mem_rd, exec_pulse, exec_type)), 32'(exp));
      if (k >= 3) begin
        chk("R4 dec", 32'(dec), 32'(8'(1) << op));
        chk("R5 mode", 32'(mode_i), 32'(md));
      end
      @(negedge clk);
    end
    done = 1'b0;
    #1;
    chk(noise ? "R9 restart" : "R8 restart", t_slot, 32'h1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset slot", t_slot, 32'h1);
    chk("R10 reset dec", 32'(dec), 32'h1);
    chk("R10 reset mode", 32'(mode_i), 32'h0);
    rst = 1'b0;
    for (int op = 0; op < 8; op++)
      for (int md = 0; md < 2; md++)
        for (int n = 0; n < 5; n++) begin
          int da;
          case (n)
            0: da = 4;
            1: da = 5;
            2: da = 9;
            3: da = 15;
            default: da = 18;
          endcase
          run_instr(3'(op), md[0], da, n[0]);
        end
    ir_top = 4'hF;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 before reset", 32'(mode_i), 32'h1);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 mid slot", t_slot, 32'h1);
    chk("R10 mid dec", 32'(dec), 32'h1);
    chk("R10 mid mode", 32'(mode_i), 32'h0);
    rst = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule